// File: doc/BRIEF.md
# Repeating Transfer Queue Controller

This block is the per-channel scheduler placed in front of a data-movement engine. Software hands it transfer handles, each tagged with a replay flag and an end-swap flag. The handles wait in a small ordered queue. They become eligible to run only after an explicit issue command. The block then gives the engine one transfer at a time through a start pulse that carries the handle and its captured configuration. It watches the engine's end pulse and decides what runs next.

When a transfer without the replay flag ends, the oldest eligible handle takes its place. When a replaying transfer ends, it starts again. The only exception is an eligible successor that carries the end-swap flag, which replaces it at that boundary. A successor without that flag is not taken, so the channel keeps replaying. Every end reports the handle and an ok/error status on a one-cycle completion strobe. Hold, release and abort-all controls act on the channel directly. The engine itself is modelled as a start/end handshake.

Top module: `rptq_ctrl`

## Requirements
- R1: After reset no start, abort or completion is signalled, the engine hold output is low, and the queue is empty.
- R2: A submitted handle never starts before an issue command. Issue makes every handle then in the queue eligible. Eligible handles start strictly in submission order.
- R3: The queue holds DEPTH (default 4) handles. While it is full, `sub_busy` is high in the cycle of a submit request, and that handle is discarded and never runs.
- R4: When a non-replaying transfer ends in cycle n, the oldest eligible handle is announced by a one-cycle `eng_start` in cycle n+2, whatever its end-swap flag. With no eligible handle, nothing starts.
- R5: A replaying transfer with no eligible successor restarts with the same handle in cycle n+2 after each end.
- R6: While a replaying transfer runs, an eligible successor without the end-swap flag is never taken. The replay continues at every end.
- R7: An eligible successor with the end-swap flag replaces a replaying transfer only at its end (start in cycle n+2). No start occurs between ends.
- R8: Each accepted end in cycle n gives `cpl_valid` high for exactly cycle n+1, with `cpl_id` equal to the ended handle and `cpl_err` equal to `eng_err` sampled with the end. An end pulse while nothing is in flight produces no completion.
- R9: A hold request raises `eng_hold` in the next cycle, and no start occurs while the hold is in force. A release clears it, after which the pending start is issued.
- R10: Abort-all empties the queue and the current slot, pulses `eng_abort` in the next cycle if a transfer was in flight, and never produces a completion for it.
- R11: `eng_cfg` of a started transfer equals the configuration value that was current when its handle was submitted. Later configuration writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load a new configuration value |
| cfg_data | input | CFG_W | Configuration value for later submits |
| sub_valid | input | 1 | Submit request |
| sub_id | input | ID_W | Handle of the submitted transfer |
| sub_repeat | input | 1 | Replay flag of the submitted transfer |
| sub_load_eot | input | 1 | End-swap flag of the submitted transfer |
| sub_busy | output | 1 | Submit refused (queue full or abort-all in same cycle) |
| issue | input | 1 | Make all queued handles eligible |
| pause | input | 1 | Hold request |
| resume | input | 1 | Release request |
| term | input | 1 | Abort-all request |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_id | output | ID_W | Handle being started/run |
| eng_cfg | output | CFG_W | Configuration captured with the handle |
| eng_hold | output | 1 | Channel held |
| eng_abort | output | 1 | In-flight transfer dropped |
| eng_done | input | 1 | Engine end-of-transfer pulse |
| eng_err | input | 1 | Error status with the end pulse |
| cpl_valid | output | 1 | Completion strobe |
| cpl_id | output | ID_W | Handle of the completed transfer |
| cpl_err | output | 1 | Completion status, 1 = error |

## Verification
The bench sweeps all four combinations of the running transfer's replay flag against the successor's end-swap flag. It checks which handle starts after each end. A block that ignored the end-swap flag would swap under a replaying transfer, and one that required it everywhere would stall a plain queue. It also fills the queue to refusal and expects no start before issue. A queue that lost its refusal would run a fifth handle, and one that ran early would start without issue. Further checks hold the channel before and during a transfer, abort with a transfer in flight (no completion, no leftover successor may run), and change configuration between submits to catch an engine that sees the live value instead of the captured one.

// File: rtl/rptq_pkg.sv
package rptq_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP,
    ACT_LOAD,
    ACT_REPLAY,
    ACT_DROP
  } slot_act_e;

  // Decide what the current slot does this cycle.
  function automatic slot_act_e pick_act(input logic cur_vld,
                                         input logic done_ok,
                                         input logic cur_rep,
                                         input logic head_rdy,
                                         input logic head_le);
    slot_act_e act;
    if (!cur_vld) begin
      act = head_rdy ? ACT_LOAD : ACT_KEEP;
    end else if (done_ok) begin
      if (head_rdy && (!cur_rep || head_le)) act = ACT_LOAD;
      else if (cur_rep)                      act = ACT_REPLAY;
      else                                   act = ACT_DROP;
    end else begin
      act = ACT_KEEP;
    end
    return act;
  endfunction

endpackage

// File: rtl/rptq_queue.sv
module rptq_queue #(
  parameter int DEPTH = 4,
  parameter int EW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [EW-1:0] push_data,
  input  logic          pop,
  input  logic          issue,
  output logic [EW-1:0] head_data,
  output logic          head_rdy,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n, rdy_q, rdy_n;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
      rdy_n = '0;
    end else begin
      wr_n  = push ? bump(wr_q) : wr_q;
      rd_n  = pop  ? bump(rd_q) : rd_q;
      cnt_n = cnt_q + CW'(push) - CW'(pop);
      // issue marks everything already stored; same-cycle pushes stay pending
      rdy_n = issue ? (cnt_q - CW'(pop)) : (rdy_q - CW'(pop));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      rdy_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      rdy_q <= rdy_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  assign head_data = mem[rd_q];
  assign head_rdy  = (rdy_q != '0);
  assign full      = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/rptq_slot.sv
module rptq_slot
  import rptq_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_rdy,
  input  logic [ID_W-1:0]  head_id,
  input  logic             head_rep,
  input  logic             head_le,
  input  logic [CFG_W-1:0] head_cfg,
  output logic             pop,
  input  logic             pause,
  input  logic             resume,
  input  logic             term,
  input  logic             eng_done,
  input  logic             eng_err,
  output logic             eng_start,
  output logic [ID_W-1:0]  eng_id,
  output logic [CFG_W-1:0] eng_cfg,
  output logic             eng_hold,
  output logic             eng_abort,
  output logic             cpl_valid,
  output logic [ID_W-1:0]  cpl_id,
  output logic             cpl_err
);
  logic             vld_q, vld_n;
  logic             run_q, run_n;
  logic             hold_q, hold_n;
  logic             start_q, start_n;
  logic             abort_q, abort_n;
  logic             cplv_q, cplv_n;
  logic [ID_W-1:0]  cur_id_q, cplid_q;
  logic [CFG_W-1:0] cur_cfg_q;
  logic             cur_rep_q, cplerr_q;
  logic             done_ok, ld_en, cpl_en;
  slot_act_e        act;

  assign done_ok = eng_done & vld_q & run_q;
  assign act     = pick_act(vld_q, done_ok, cur_rep_q, head_rdy, head_le);
  assign ld_en   = !term && (act == ACT_LOAD);
  assign cpl_en  = done_ok && !term;
  assign pop     = ld_en;

  always_comb begin
    hold_n  = pause ? 1'b1 : (resume ? 1'b0 : hold_q);
    start_n = 1'b0;
    abort_n = term & vld_q & run_q;
    cplv_n  = cpl_en;
    vld_n   = vld_q;
    run_n   = run_q;
    if (term) begin
      vld_n = 1'b0;
      run_n = 1'b0;
    end else begin
      unique case (act)
        ACT_LOAD: begin
          vld_n = 1'b1;
          run_n = 1'b0;
        end
        ACT_REPLAY: run_n = 1'b0;
        ACT_DROP: begin
          vld_n = 1'b0;
          run_n = 1'b0;
        end
        default: begin
          if (vld_q && !run_q && !hold_q) begin
            run_n   = 1'b1;
            start_n = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      run_q   <= 1'b0;
      hold_q  <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
      cplv_q  <= 1'b0;
    end else begin
      vld_q   <= vld_n;
      run_q   <= run_n;
      hold_q  <= hold_n;
      start_q <= start_n;
      abort_q <= abort_n;
      cplv_q  <= cplv_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_id_q  <= '0;
      cur_cfg_q <= '0;
      cur_rep_q <= 1'b0;
    end else if (ld_en) begin
      cur_id_q  <= head_id;
      cur_cfg_q <= head_cfg;
      cur_rep_q <= head_rep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cplid_q  <= '0;
      cplerr_q <= 1'b0;
    end else if (cpl_en) begin
      cplid_q  <= cur_id_q;
      cplerr_q <= eng_err;
    end
  end

  assign eng_start = start_q;
  assign eng_id    = cur_id_q;
  assign eng_cfg   = cur_cfg_q;
  assign eng_hold  = hold_q;
  assign eng_abort = abort_q;
  assign cpl_valid = cplv_q;
  assign cpl_id    = cplid_q;
  assign cpl_err   = cplerr_q;

endmodule

// File: rtl/rptq_ctrl.sv
module rptq_ctrl #(
  parameter int DEPTH = 4,
  parameter int ID_W  = 4,
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             sub_valid,
  input  logic [ID_W-1:0]  sub_id,
  input  logic             sub_repeat,
  input  logic             sub_load_eot,
  output logic             sub_busy,
  input  logic             issue,
  input  logic             pause,
  input  logic             resume,
  input  logic             term,
  output logic             eng_start,
  output logic [ID_W-1:0]  eng_id,
  output logic [CFG_W-1:0] eng_cfg,
  output logic             eng_hold,
  output logic             eng_abort,
  input  logic             eng_done,
  input  logic             eng_err,
  output logic             cpl_valid,
  output logic [ID_W-1:0]  cpl_id,
  output logic             cpl_err
);
  localparam int EW = ID_W + 2 + CFG_W;

  logic [CFG_W-1:0] cfg_q;
  logic             q_full, q_push, q_pop, q_rdy;
  logic [EW-1:0]    q_in, q_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_data;
  end

  assign sub_busy = sub_valid & (q_full | term);
  assign q_push   = sub_valid & !q_full & !term;
  assign q_in     = {sub_id, sub_repeat, sub_load_eot, cfg_q};

  rptq_queue #(.DEPTH(DEPTH), .EW(EW)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (term),
    .push      (q_push),
    .push_data (q_in),
    .pop       (q_pop),
    .issue     (issue),
    .head_data (q_head),
    .head_rdy  (q_rdy),
    .full      (q_full)
  );

  rptq_slot #(.ID_W(ID_W), .CFG_W(CFG_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .head_rdy  (q_rdy),
    .head_id   (q_head[EW-1 -: ID_W]),
    .head_rep  (q_head[CFG_W+1]),
    .head_le   (q_head[CFG_W]),
    .head_cfg  (q_head[CFG_W-1:0]),
    .pop       (q_pop),
    .pause     (pause),
    .resume    (resume),
    .term      (term),
    .eng_done  (eng_done),
    .eng_err   (eng_err),
    .eng_start (eng_start),
    .eng_id    (eng_id),
    .eng_cfg   (eng_cfg),
    .eng_hold  (eng_hold),
    .eng_abort (eng_abort),
    .cpl_valid (cpl_valid),
    .cpl_id    (cpl_id),
    .cpl_err   (cpl_err)
  );

endmodule

// File: rtl/rptq_ctrl_chk.sv
module rptq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sub_valid,
  input logic sub_busy,
  input logic pause,
  input logic term,
  input logic eng_start,
  input logic eng_hold,
  input logic eng_abort,
  input logic eng_done,
  input logic cpl_valid
);
  assert_busy_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sub_busy |-> sub_valid);

  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_cpl_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> $past(eng_done));

  assert_hold_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pause) |-> eng_hold);

  assert_no_start_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !$past(eng_hold));

  assert_no_cpl_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> !$past(term));

  assert_abort_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> $past(term));

endmodule

bind rptq_ctrl rptq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sub_valid (sub_valid),
  .sub_busy  (sub_busy),
  .pause     (pause),
  .term      (term),
  .eng_start (eng_start),
  .eng_hold  (eng_hold),
  .eng_abort (eng_abort),
  .eng_done  (eng_done),
  .cpl_valid (cpl_valid)
);

// File: tb/tb_rptq_ctrl.sv
module tb_rptq_ctrl;
  localparam int DEPTH = 4;
  localparam int ID_W  = 4;
  localparam int CFG_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr, sub_valid, sub_repeat, sub_load_eot, issue, pause, resume, term;
  logic eng_done, eng_err;
  logic [CFG_W-1:0] cfg_data;
  logic [ID_W-1:0]  sub_id;
  logic sub_busy, eng_start, eng_hold, eng_abort, cpl_valid, cpl_err;
  logic [ID_W-1:0]  eng_id, cpl_id;
  logic [CFG_W-1:0] eng_cfg;

  int vec = 0;
  int bad = 0;

  always #10 clk = ~clk;

  rptq_ctrl #(.DEPTH(DEPTH), .ID_W(ID_W), .CFG_W(CFG_W)) dut (.*);

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic submit(int id, bit rep, bit le, bit exp_busy);
    sub_valid = 1'b1; sub_id = ID_W'(id); sub_repeat = rep; sub_load_eot = le;
    chk("R3 busy on submit", int'(sub_busy), int'(exp_busy));
    tick();
    sub_valid = 1'b0;
  endtask

  task automatic do_issue();
    issue = 1'b1; tick(); issue = 1'b0;
  endtask

  task automatic end_xfer(bit err, int exp_id);
    eng_done = 1'b1; eng_err = err;
    tick();
    eng_done = 1'b0; eng_err = 1'b0;
    chk("R8 cpl_valid", int'(cpl_valid), 1);
    chk("R8 cpl_id", int'(cpl_id), exp_id);
    chk("R8 cpl_err", int'(cpl_err), int'(err));
  endtask

  task automatic wait_start(output int id, output int cfg);
    id = -1; cfg = -1;
    for (int i = 0; i < 12; i++) begin
      if (eng_start) begin
        id = int'(eng_id); cfg = int'(eng_cfg);
        tick();
        return;
      end
      tick();
    end
  endtask

  task automatic quiet(int n, string tag);
    int cnt = 0;
    repeat (n) begin
      if (eng_start) cnt++;
      tick();
    end
    chk(tag, cnt, 0);
  endtask

  task automatic abort_all(bit exp_abort);
    term = 1'b1; tick(); term = 1'b0;
    chk("R10 abort pulse", int'(eng_abort), int'(exp_abort));
    chk("R10 no completion", int'(cpl_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    int id, cfg, exp_id;
    rst_n = 1'b0;
    {cfg_wr, sub_valid, sub_repeat, sub_load_eot, issue, pause, resume, term} = '0;
    {eng_done, eng_err} = '0;
    cfg_data = '0; sub_id = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 start", int'(eng_start), 0);
    chk("R1 cpl", int'(cpl_valid), 0);
    chk("R1 hold", int'(eng_hold), 0);
    chk("R1 abort", int'(eng_abort), 0);
    quiet(3, "R1 idle no start");

    // R8: end pulse while idle is ignored
    eng_done = 1'b1; tick(); eng_done = 1'b0;
    chk("R8 idle end ignored", int'(cpl_valid), 0);

    // R2 R3 R11: fill queue, capture configuration per submit
    cfg_wr = 1'b1; cfg_data = 4'd5; tick(); cfg_wr = 1'b0;
    submit(10, 1'b0, 1'b0, 1'b0);
    cfg_wr = 1'b1; cfg_data = 4'd9; tick(); cfg_wr = 1'b0;
    for (int i = 1; i < DEPTH; i++) submit(10 + i, 1'b0, 1'(i % 2), 1'b0);
    submit(14, 1'b0, 1'b0, 1'b1);
    quiet(5, "R2 no start before issue");
    do_issue();
    wait_start(id, cfg);
    chk("R2 first handle", id, 10);
    chk("R11 captured cfg", cfg, 5);
    for (int i = 1; i < DEPTH; i++) begin
      end_xfer(1'(i % 2), 10 + i - 1);
      wait_start(id, cfg);
      chk("R4 next in order", id, 10 + i);
      chk("R11 later cfg", cfg, 9);
    end
    end_xfer(1'b0, 13);
    quiet(6, "R3 refused handle never runs");

    // R5 R6 R7 R10: sweep replay flag against successor end-swap flag
    for (int cr = 0; cr < 2; cr++) begin
      for (int sl = 0; sl < 2; sl++) begin
        submit(1, 1'(cr), 1'b0, 1'b0);
        do_issue();
        wait_start(id, cfg);
        chk("R2 sweep first", id, 1);
        if (cr == 1) begin
          end_xfer(1'b0, 1);
          wait_start(id, cfg);
          chk("R5 replay without successor", id, 1);
        end
        submit(2, 1'b0, 1'(sl), 1'b0);
        do_issue();
        quiet(4, "R7 no swap mid transfer");
        end_xfer(1'(cr ^ sl), 1);
        exp_id = (cr == 1 && sl == 0) ? 1 : 2;
        wait_start(id, cfg);
        chk((cr == 1) ? "R7 R6 swap decision" : "R4 flag irrelevant", id, exp_id);
        if (exp_id == 1) begin
          end_xfer(1'b1, 1);
          wait_start(id, cfg);
          chk("R6 successor still skipped", id, 1);
        end
        abort_all(1'b1);
        quiet(5, "R10 queue flushed");
      end
    end

    // R9: hold before a transfer and while one runs
    pause = 1'b1; tick(); pause = 1'b0;
    chk("R9 hold raised", int'(eng_hold), 1);
    submit(7, 1'b1, 1'b0, 1'b0);
    do_issue();
    quiet(6, "R9 no start while held");
    resume = 1'b1; tick(); resume = 1'b0;
    chk("R9 hold released", int'(eng_hold), 0);
    wait_start(id, cfg);
    chk("R9 start after release", id, 7);
    pause = 1'b1; tick(); pause = 1'b0;
    end_xfer(1'b0, 7);
    quiet(5, "R9 no replay while held");
    resume = 1'b1; tick(); resume = 1'b0;
    wait_start(id, cfg);
    chk("R9 replay after release", id, 7);
    abort_all(1'b1);
    abort_all(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule